// File: doc/BRIEF.md
# Memory-Mapped Bus I/O Port

This block is a small peripheral on a processor bus that has a 16-bit address, an 8-bit data path and one direction line. The direction line is high for a processor read and low for a processor write. The port provides two byte-wide resources, each at its own address inside the low 16K of the map, where both top address bits are zero:

- An output latch that drives a set of external loads.
- An input port that samples a set of external pins.

The block samples every bus line on a free-running system clock through a two-flop synchroniser. A small state machine follows the direction line. When a write to the latch slot ends, marked by the direction line returning high, the machine copies into the latch the data and address registered on the cycle before that rise. The latch keeps its value after the address moves away.

A read of the input slot drives the synchronised pins onto the bus. The three-state data pins are modelled as a separate data-out vector plus an output-enable. At all other times the enable stays low and the data-out vector is zero.

A static mode input selects between two decode schemes:

- **Partial decode:** only the top two address bits and the low three slot bits are examined, so the two resources repeat every eight locations.
- **Full decode:** any set bit among address bits 13 down to 3 also deselects the port.

The state machine has two states:

- **ST_IDLE:** the synchronised direction line is high.
- **ST_WRITE:** a processor write is in progress.

It has two transitions:

- **write start:** ST_IDLE to ST_WRITE, taken when the synchronised direction line is seen low.
- **write end:** ST_WRITE to ST_IDLE, taken when the synchronised direction line is seen high again. This transition is the only moment the latch can load.

Top module: `bus_io_port`

## Requirements
- R1: While synchronous reset `rst` is high, and on the first clock after it, the latch `out_q` reads 0x00 and `bus_oe` is low, even if a read of the input slot is on the bus.
- R2: When address bit 15 or bit 14 is 1, the port never asserts `bus_oe`, and a write to that address leaves `out_q` unchanged.
- R3: `bus_oe` may be high only if `bus_rw` was 1 two clock cycles earlier. While a write is held on the bus, `bus_oe` is low.
- R4: A write (`bus_rw` going 0 and then back to 1) whose address selects slot 0 (address bits 2:0 = 000) loads `out_q` with `bus_din`. The new value is visible within five clocks of the rising edge of `bus_rw`. It then holds through later bus traffic to other addresses.
- R5: A read (`bus_rw` = 1) whose address selects slot 1 (address bits 2:0 = 001) raises `bus_oe` two clocks after the address settles, with `bus_dout` bit k equal to `pins_in` bit k. Whenever `bus_oe` is low, `bus_dout` is 0x00.
- R6: With `full_decode` = 0, address bits 13:3 are ignored, so for example address 8 loads the latch and address 9 reads the pins.
- R7: With `full_decode` = 1, any 1 among address bits 13:3 deselects the port: no latch load and no `bus_oe`.
- R8: Slots 2 to 7 (address bits 2:0 from 010 to 111) have no effect: writes leave `out_q` unchanged and reads leave `bus_oe` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock that samples the bus |
| rst | input | 1 | Synchronous reset, active high |
| full_decode | input | 1 | 1 selects full decode of address bits 13:3, 0 selects partial decode |
| bus_addr | input | 16 | Processor address bus |
| bus_rw | input | 1 | Direction line: 1 for a processor read, 0 for a processor write |
| bus_din | input | 8 | Data bus as driven by the processor |
| bus_dout | output | 8 | Data the port puts on the bus when enabled, zero otherwise |
| bus_oe | output | 1 | Output-enable for the data bus drivers |
| pins_in | input | 8 | External input pins read through slot 1 |
| out_q | output | 8 | Output latch driving the external loads |

## Verification
The bench sweeps both decode modes over every slot of the first sixteen addresses and over addresses that set bit 15, bit 14, or the mid bits 13:3. For each address it computes arithmetically whether a write should load the latch and whether a read should drive the pins.

The sweep targets the following faults:

- A decoder that forgets a top bit would load the latch from an address that belongs to main memory or graphics.
- A decoder with the mode inverted would miss the alias at address 8 or accept address 0x3FF8 in full mode.
- A latch that loads on the falling edge of the direction line instead of the rise, or loads from the wrong slot, shows up when the bench reads the latch back.
- Checks taken while the direction line is held low catch an enable that ignores the write condition.

A full 0 to 255 counting pattern to address 0 exposes stuck or swapped data bits. A reset applied in the middle of a pending read confirms that both the latch and the enable clear.

// File: rtl/bus_io_pkg.sv
package bus_io_pkg;

    // Write-tracking state machine encoding.
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,   // synchronised direction line is high
        ST_WRITE = 1'b1    // processor write in progress
    } wr_state_t;

    // Defaults shared by the block and its checker.
    localparam int unsigned DEF_ADDR_W      = 16;
    localparam int unsigned DEF_DATA_W      = 8;
    localparam int unsigned DEF_SLOT_W      = 3;
    localparam int unsigned DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/bus_io_sync.sv
// Multi-stage synchroniser with a per-bit reset value.
module bus_io_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= RST_VAL;
                else     stage_q[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= RST_VAL;
                else     stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/bus_io_decode.sv
// Address decoder for one slot of the low-16K peripheral window.
module bus_io_decode #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned SLOT_W = 3,
    parameter int unsigned TARGET = 0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              full_mode,
    output logic              hit
);

    localparam int unsigned MID_HI = ADDR_W - 3;
    localparam int unsigned MID_W  = MID_HI - SLOT_W + 1;
    localparam logic [SLOT_W-1:0] SLOT_CODE = SLOT_W'(TARGET);

    logic window_ok;
    logic mid_clear;
    logic slot_match;

    // Both top address bits must be zero for the window to be free.
    assign window_ok  = (addr[ADDR_W-1 -: 2] == 2'b00);
    assign mid_clear  = (addr[MID_HI:SLOT_W] == {MID_W{1'b0}});
    assign slot_match = (addr[SLOT_W-1:0] == SLOT_CODE);

    assign hit = window_ok && slot_match && (!full_mode || mid_clear);

endmodule

// File: rtl/bus_io_wr_fsm.sv
// Tracks the direction line and loads the output latch when a write ends.
module bus_io_wr_fsm
    import bus_io_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned SLOT_W   = 3,
    parameter int unsigned OUT_SLOT = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              full_mode,
    input  logic              rw_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] data_s,
    output logic [DATA_W-1:0] out_q
);

    wr_state_t         state_q, state_d;
    logic [ADDR_W-1:0] addr_q;     // address one cycle behind the synchroniser
    logic [DATA_W-1:0] data_q;     // data one cycle behind the synchroniser
    logic              prev_hit;
    logic              commit;

    // Hold the bus value from the cycle before the rise of the direction line.
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '1;
            data_q <= '0;
        end else begin
            addr_q <= addr_s;
            data_q <= data_s;
        end
    end

    bus_io_decode #(
        .ADDR_W (ADDR_W),
        .SLOT_W (SLOT_W),
        .TARGET (OUT_SLOT)
    ) u_dec_wr (
        .addr      (addr_q),
        .full_mode (full_mode),
        .hit       (prev_hit)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        commit  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!rw_s) state_d = ST_WRITE;      // write start
            end
            ST_WRITE: begin
                if (rw_s) begin                     // write end
                    state_d = ST_IDLE;
                    commit  = prev_hit;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Output latch.
    always_ff @(posedge clk) begin
        if (rst)         out_q <= '0;
        else if (commit) out_q <= data_q;
    end

endmodule

// File: rtl/bus_io_port.sv
// Memory-mapped byte output latch and byte input port.
module bus_io_port #(
    parameter int unsigned ADDR_W      = bus_io_pkg::DEF_ADDR_W,
    parameter int unsigned DATA_W      = bus_io_pkg::DEF_DATA_W,
    parameter int unsigned SLOT_W      = bus_io_pkg::DEF_SLOT_W,
    parameter int unsigned OUT_SLOT    = 0,
    parameter int unsigned IN_SLOT     = 1,
    parameter int unsigned SYNC_STAGES = bus_io_pkg::DEF_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              full_decode,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rw,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_oe,
    input  logic [DATA_W-1:0] pins_in,
    output logic [DATA_W-1:0] out_q
);

    localparam int unsigned BUNDLE_W = 1 + ADDR_W + 2 * DATA_W;
    // Reset values: direction line high (read), address in main memory.
    localparam logic [BUNDLE_W-1:0] BUNDLE_RST =
        {1'b1, {ADDR_W{1'b1}}, {(2 * DATA_W){1'b0}}};

    logic [BUNDLE_W-1:0] bundle_s;
    logic                rw_s;
    logic [ADDR_W-1:0]   addr_s;
    logic [DATA_W-1:0]   data_s;
    logic [DATA_W-1:0]   pins_s;
    logic                rd_hit;

    bus_io_sync #(
        .W       (BUNDLE_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (BUNDLE_RST)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({bus_rw, bus_addr, bus_din, pins_in}),
        .q   (bundle_s)
    );

    assign {rw_s, addr_s, data_s, pins_s} = bundle_s;

    bus_io_decode #(
        .ADDR_W (ADDR_W),
        .SLOT_W (SLOT_W),
        .TARGET (IN_SLOT)
    ) u_dec_rd (
        .addr      (addr_s),
        .full_mode (full_decode),
        .hit       (rd_hit)
    );

    // Read path: combinational enable from the synchronised decode.
    assign bus_oe   = !rst && rw_s && rd_hit;
    assign bus_dout = bus_oe ? pins_s : '0;

    bus_io_wr_fsm #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .SLOT_W   (SLOT_W),
        .OUT_SLOT (OUT_SLOT)
    ) u_wr (
        .clk       (clk),
        .rst       (rst),
        .full_mode (full_decode),
        .rw_s      (rw_s),
        .addr_s    (addr_s),
        .data_s    (data_s),
        .out_q     (out_q)
    );

endmodule

// File: rtl/bus_io_port_chk.sv
// Property checker for bus_io_port (assumes a two-stage synchroniser).
module bus_io_port_chk #(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned SLOT_W   = 3,
    parameter int unsigned OUT_SLOT = 0,
    parameter int unsigned IN_SLOT  = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              full_decode,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rw,
    input logic [DATA_W-1:0] bus_din,
    input logic [DATA_W-1:0] bus_dout,
    input logic              bus_oe,
    input logic [DATA_W-1:0] pins_in,
    input logic [DATA_W-1:0] out_q
);

    localparam logic [SLOT_W-1:0] OUT_CODE = SLOT_W'(OUT_SLOT);
    localparam logic [SLOT_W-1:0] IN_CODE  = SLOT_W'(IN_SLOT);

    logic [2:0] age_q;   // cycles since reset, saturating
    logic       rst_d;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst)               age_q <= '0;
        else if (age_q != 3'd7) age_q <= age_q + 3'd1;
    end

    // R1: latch cleared and enable low right after a reset cycle.
    always @(negedge clk) begin
        if (rst_d) begin
            a_r1_reset_state: assert (out_q == '0 && !bus_oe);
        end
    end

    // R2: no drive when either top address bit was set.
    a_r2_no_drive_upper: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> ($past(bus_addr[ADDR_W-1 -: 2], 2) == 2'b00));

    // R3: no drive unless the direction line indicated a read.
    a_r3_no_drive_write: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> $past(bus_rw, 2));

    // R5: drive only for the input slot, with the synchronised pin value.
    a_r5_read_slot: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> ($past(bus_addr[SLOT_W-1:0], 2) == IN_CODE));

    a_r5_read_data: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> (bus_dout == $past(pins_in, 2)));

    // R7: full decode forbids any set mid address bit while driving.
    a_r7_full_mid_clear: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && $past(full_decode, 2)) |->
            ($past(bus_addr[ADDR_W-3:SLOT_W], 2) == '0));

    // R4: the latch moves only after a low-to-high direction transition.
    a_r4_load_on_rise: assert property (@(posedge clk) disable iff (rst)
        (age_q == 3'd7 && !$stable(out_q)) |->
            ($past(bus_rw, 3) && !$past(bus_rw, 4)));

    // R4/R8: the loaded value is the pre-rise data for the output slot.
    a_r4_load_data: assert property (@(posedge clk) disable iff (rst)
        (age_q == 3'd7 && !$stable(out_q)) |->
            (out_q == $past(bus_din, 4) &&
             $past(bus_addr[SLOT_W-1:0], 4) == OUT_CODE &&
             $past(bus_addr[ADDR_W-1 -: 2], 4) == 2'b00));

endmodule

bind bus_io_port bus_io_port_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SLOT_W   (SLOT_W),
    .OUT_SLOT (OUT_SLOT),
    .IN_SLOT  (IN_SLOT)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .full_decode (full_decode),
    .bus_addr    (bus_addr),
    .bus_rw      (bus_rw),
    .bus_din     (bus_din),
    .bus_dout    (bus_dout),
    .bus_oe      (bus_oe),
    .pins_in     (pins_in),
    .out_q       (out_q)
);

// File: tb/sim_bus_io_port.sv
`timescale 1ns/1ps
module sim_bus_io_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        full_decode = 1'b0;
    logic [15:0] bus_addr = 16'h3FFF;
    logic        bus_rw = 1'b1;
    logic [7:0]  bus_din = 8'h00;
    logic [7:0]  bus_dout;
    logic        bus_oe;
    logic [7:0]  pins_in = 8'h00;
    logic [7:0]  out_q;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] exp_out = 8'h00;

    always #2.5 clk = ~clk;   // 200 MHz

    bus_io_port u0 (
        .clk (clk), .rst (rst), .full_decode (full_decode),
        .bus_addr (bus_addr), .bus_rw (bus_rw), .bus_din (bus_din),
        .bus_dout (bus_dout), .bus_oe (bus_oe), .pins_in (pins_in),
        .out_q (out_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic selected(input logic [15:0] a, input logic full);
        return (a[15:14] == 2'b00) && (!full || a[13:3] == 11'd0);
    endfunction

    function automatic string tag_of(input logic [15:0] a, input logic full, input logic is_wr);
        if (a[15:14] != 2'b00)               return "R2";
        if (full && a[13:3] != 11'd0)        return "R7";
        if (!full && a[13:3] != 11'd0)       return "R6";
        if (is_wr && a[2:0] == 3'd0)         return "R4";
        if (!is_wr && a[2:0] == 3'd1)        return "R5";
        return "R8";
    endfunction

    // One processor write; checks the enable while the write is held.
    task automatic bus_write(input logic [15:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_din = v; bus_rw = 1'b1;
        repeat (3) @(negedge clk);
        bus_rw = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 oe during write", {31'd0, bus_oe}, 32'd0);
        @(negedge clk);
        bus_rw = 1'b1;
        repeat (5) @(negedge clk);
        bus_addr = 16'h3FFF;
        if (selected(a, full_decode) && a[2:0] == 3'd0) exp_out = v;
    endtask

    task automatic bus_read(input logic [15:0] a, input logic [7:0] p);
        logic hit;
        @(negedge clk);
        bus_addr = a; bus_rw = 1'b1; pins_in = p;
        repeat (3) @(negedge clk);
        hit = selected(a, full_decode) && a[2:0] == 3'd1;
        chk({tag_of(a, full_decode, 1'b0), " read oe"}, {31'd0, bus_oe}, {31'd0, hit});
        chk({tag_of(a, full_decode, 1'b0), " read data"}, {24'd0, bus_dout},
            {24'd0, hit ? p : 8'h00});
        bus_addr = 16'h3FFF;
    endtask

    localparam logic [15:0] EXTRA [8] = '{16'h4000, 16'h8000, 16'hC001, 16'h4001,
                                          16'h8001, 16'h3FF8, 16'h3FF9, 16'h0200};

    initial begin
        #(5.0 * 150000);
        n_fail++; n_chk++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk("R1 out in reset", {24'd0, out_q}, 32'd0);
        chk("R1 oe in reset", {31'd0, bus_oe}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 out after reset", {24'd0, out_q}, 32'd0);

        // Counting pattern to the latch slot (R4).
        for (int v = 0; v < 256; v++) begin
            bus_write(16'h0000, 8'(v));
            chk("R4 count", {24'd0, out_q}, {24'd0, exp_out});
        end

        // Sweep both decode modes over slots and boundary addresses.
        for (int m = 0; m < 2; m++) begin
            full_decode = m[0];
            for (int i = 0; i < 24; i++) begin
                logic [15:0] a;
                logic [7:0]  v;
                a = (i < 16) ? 16'(i) : EXTRA[i-16];
                v = 8'(i * 37 + m * 91 + 5);
                bus_write(16'h0000, ~v);   // known baseline
                bus_write(a, v);
                chk({tag_of(a, full_decode, 1'b1), " write"}, {24'd0, out_q}, {24'd0, exp_out});
                bus_read(a, 8'(i * 29 + m * 13 + 1));
                bus_read(a, 8'hFF ^ 8'(i));
                chk({tag_of(a, full_decode, 1'b1), " hold"}, {24'd0, out_q}, {24'd0, exp_out});
            end
        end

        // R1: reset during a pending read of the input slot.
        full_decode = 1'b0;
        bus_write(16'h0000, 8'hA5);
        chk("R4 pre-reset", {24'd0, out_q}, 32'hA5);
        @(negedge clk);
        bus_addr = 16'h0001; pins_in = 8'h3C; rst = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 out mid reset", {24'd0, out_q}, 32'd0);
        chk("R1 oe mid reset", {31'd0, bus_oe}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 oe after reset", {31'd0, bus_oe}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R5 read after reset", {24'd0, bus_dout}, 32'h3C);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule